// File: doc/BRIEF.md
# Iterative Signed Double-Word Multiplier With Four-Word Product

This block multiplies two signed double-word integers and returns a four-word (quad) product. An operand is a 36-bit high word and a 36-bit low word. Only the top bit of the high word carries the sign. The top bit of the low word is discarded, so a double-word holds 71 significant bits in two's complement. Both operands are first reduced to magnitudes. A sequential shift-and-add loop of 71 steps then forms the 141-bit unsigned product. If the operand signs differ, the whole quad is negated.

The result is written as four 36-bit words. The top word holds the top 36 bits of the product. Each lower word holds 35 product bits in bits 34:0, and its bit 35 repeats the sign of the top word. A caller raises `start` for one cycle when the block is idle. The block runs 71 clock steps and then pulses `done` together with the new product. If the operands have the same sign but the product reads as negative (the largest negative value squared), both `ovf` and `trap1` are raised with the result.

Top module: `dmul_quad`

## Requirements
- R1: Bit 35 of `a_lo` and of `b_lo` has no effect on any output; each low word contributes only bits 34:0.
- R2: The 141-bit two's complement value {p0, p1[34:0], p2[34:0], p3[34:0]} equals the product of the two signed 71-bit operands {x_hi, x_lo[34:0]}, truncated to 141 bits.
- R3: If either operand is zero, p0..p3 are all zero and neither flag is set.
- R4: `done` is high for exactly one cycle. It rises 71 clock edges after the edge that accepts `start`.
- R5: Bit 35 of each of p1, p2 and p3 equals bit 35 of p0.
- R6: `ovf` and `trap1` are both 1 exactly when the operand signs agree and p0 bit 35 is 1. Otherwise both are 0. They are updated together with `done`.
- R7: A `start` pulse while an operation is in progress is ignored. The running operation completes with its own operands on its own schedule.
- R8: After reset, `done`, p0..p3, `ovf` and `trap1` are zero. The product words and flags hold their values between `done` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiply when idle |
| a_hi | input | 36 | Multiplicand high word (bit 35 is the sign) |
| a_lo | input | 36 | Multiplicand low word (bit 35 ignored) |
| b_hi | input | 36 | Multiplier high word (bit 35 is the sign) |
| b_lo | input | 36 | Multiplier low word (bit 35 ignored) |
| done | output | 1 | One-cycle pulse when the product is written |
| p0 | output | 36 | Most significant product word |
| p1 | output | 36 | Second product word |
| p2 | output | 36 | Third product word |
| p3 | output | 36 | Least significant product word |
| ovf | output | 1 | Arithmetic overflow flag |
| trap1 | output | 1 | Trap flag, raised with `ovf` |

## Verification
The block samples `start` on one edge, and its product words, flags and `done` appear together 71 edges later. The bench counts edges from the accepting edge and samples `done` between edges on every cycle up to one past the expected one. It requires `done` low on every cycle before edge 71, high after edge 71, and low again after edge 72. The product and flags are compared after edge 71 and again one cycle later, which shows that they hold. A second `start` is injected partway through some runs, and the result must still belong to the first operands and arrive on the first schedule.

// File: rtl/dmul_quad.sv
module dmul_quad #(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] a_hi,
  input  logic [W-1:0] a_lo,
  input  logic [W-1:0] b_hi,
  input  logic [W-1:0] b_lo,
  output logic         done,
  output logic [W-1:0] p0,
  output logic [W-1:0] p1,
  output logic [W-1:0] p2,
  output logic [W-1:0] p3,
  output logic         ovf,
  output logic         trap1
);
  localparam int L    = W - 1;
  localparam int M    = W + L;
  localparam int Q    = W + 3 * L;
  localparam int ITER = M;
  localparam int CW   = $clog2(ITER + 1);

  function automatic logic [M-1:0] mag(input logic [W-1:0] hi, input logic [W-1:0] lo);
    logic [M-1:0] v;
    v = {hi, lo[L-1:0]};
    return hi[W-1] ? (~v + 1'b1) : v;
  endfunction

  logic          busy;
  logic [CW-1:0] cnt;
  logic [M-1:0]  mpc, mpy;
  logic          neg;
  logic [Q-1:0]  acc;

  logic          first, last, take;
  logic [Q-1:0]  acc_sh, acc_nx, res;
  logic [M-1:0]  mpy_sh;
  logic          top;

  assign first  = (cnt == '0);
  assign last   = busy && (cnt == CW'(ITER - 1));
  assign take   = start && !busy;
  assign acc_sh = first ? acc : (acc >> 1);
  assign mpy_sh = first ? mpy : (mpy >> 1);
  assign acc_nx = acc_sh + (mpy_sh[0] ? {mpc, {(Q-M){1'b0}}} : '0);
  assign res    = neg ? (~acc_nx + 1'b1) : acc_nx;
  assign top    = res[Q-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      mpc  <= '0;
      mpy  <= '0;
      neg  <= 1'b0;
      acc  <= '0;
    end else if (take) begin
      busy <= 1'b1;
      cnt  <= '0;
      mpc  <= mag(a_hi, a_lo);
      mpy  <= mag(b_hi, b_lo);
      neg  <= a_hi[W-1] ^ b_hi[W-1];
      acc  <= '0;
    end else if (busy) begin
      acc  <= acc_nx;
      mpy  <= mpy_sh;
      cnt  <= cnt + 1'b1;
      if (last) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done  <= 1'b0;
      p0    <= '0;
      p1    <= '0;
      p2    <= '0;
      p3    <= '0;
      ovf   <= 1'b0;
      trap1 <= 1'b0;
    end else begin
      done <= last;
      if (last) begin
        p0    <= res[Q-1 -: W];
        p1    <= {top, res[3*L-1 -: L]};
        p2    <= {top, res[2*L-1 -: L]};
        p3    <= {top, res[L-1:0]};
        ovf   <= !neg && top;
        trap1 <= !neg && top;
      end
    end
  end

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < CW'(ITER)));

  // R5
  low_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (p1[W-1] == p0[W-1]) && (p2[W-1] == p0[W-1]) && (p3[W-1] == p0[W-1]));

  // R6
  ovf_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> p0[W-1] && p3[W-1] && (ovf == trap1));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(p0) && $stable(p3) && $stable(ovf));
endmodule

// File: tb/dmul_quad_test.sv
module dmul_quad_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [35:0] a_hi = '0, a_lo = '0, b_hi = '0, b_lo = '0;
  logic        done, ovf, trap1;
  logic [35:0] p0, p1, p2, p3;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  dmul_quad uut (.clk(clk), .rst_n(rst_n), .start(start), .a_hi(a_hi), .a_lo(a_lo),
                 .b_hi(b_hi), .b_lo(b_lo), .done(done), .p0(p0), .p1(p1), .p2(p2),
                 .p3(p3), .ovf(ovf), .trap1(trap1));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [143:0] act, input logic [143:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [35:0] ah, input logic [35:0] al,
                     input logic [35:0] bh, input logic [35:0] bl,
                     input bit inject, input string tag);
    logic signed [70:0]  xa, xb;
    logic signed [141:0] sa, sb, pr;
    logic [140:0]        q;
    logic [35:0]         e0, e1, e2, e3;
    logic                eov;
    xa = {ah, al[34:0]};
    xb = {bh, bl[34:0]};
    sa = xa;
    sb = xb;
    pr = sa * sb;
    q  = pr[140:0];
    e0 = q[140:105];
    e1 = {q[140], q[104:70]};
    e2 = {q[140], q[69:35]};
    e3 = {q[140], q[34:0]};
    eov = !pr[141] && pr[140];
    @(negedge clk);
    a_hi = ah; a_lo = al; b_hi = bh; b_lo = bl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= 72; k++) begin
      @(negedge clk);
      // R4: done only after edge 71
      chk(done == (k == 71), {tag, " R4 done timing"}, 144'(done), 144'(k == 71));
      if (k == 71 || k == 72) begin
        // R2 / R5 / R8 product words, held on k==72
        chk({p0, p1, p2, p3} == {e0, e1, e2, e3}, {tag, " R2 R5 R8 product"},
            144'({p0, p1, p2, p3}), 144'({e0, e1, e2, e3}));
        // R6
        chk(ovf == eov && trap1 == eov, {tag, " R6 flags"}, 144'({ovf, trap1}), 144'({eov, eov}));
      end
      if (inject && k == 10) begin
        // R7: new request while busy
        a_hi = 36'h123456789; a_lo = 36'h0abcdef01; b_hi = 36'h800000001; b_lo = 36'h7ffffffff;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(done == 0 && {p0, p1, p2, p3} == '0 && ovf == 0 && trap1 == 0, "R8 reset",
        144'({done, ovf, trap1, p0}), 144'(0));
    rst_n = 1'b1;
    @(negedge clk);
    run(36'o400000000000, 36'o0, 36'o400000000000, 36'o0, 0, "maxneg squared");
    run(36'o0, 36'o0, 36'o777777777777, 36'o777777777777, 0, "R3 zero times neg");
    run(36'o123456701234, 36'o012345670123, 36'o0, 36'o0, 0, "R3 pos times zero");
    run(36'o777777777777, 36'o777777777777, 36'o777777777777, 36'o777777777777, 0, "minus one squared");
    run(36'o777777777777, 36'o777777777777, 36'o0, 36'o1, 0, "minus one times one");
    run(36'o377777777777, 36'o377777777777, 36'o377777777777, 36'o377777777777, 0, "maxpos squared");
    run(36'o400000000000, 36'o0, 36'o0, 36'o1, 0, "maxneg times one");
    run(36'o000000000005, 36'o400000000003, 36'o000000000007, 36'o400000000002, 0, "R1 low sign set");
    run(36'o700000000001, 36'o412345670000, 36'o000000000002, 36'o777777777777, 0, "R1 neg low sign set");
    run(36'o0, 36'o000000000123, 36'o777777777776, 36'o0, 1, "R7 inject small");
    run(36'o400000000000, 36'o0, 36'o400000000000, 36'o0, 1, "R7 inject maxneg");
    for (int i = 0; i < 24; i++) begin
      logic [35:0] r0, r1, r2, r3;
      r0 = {$urandom, $urandom}; r1 = {$urandom, $urandom};
      r2 = {$urandom, $urandom}; r3 = {$urandom, $urandom};
      run(r0, r1, r2, r3, (i % 5) == 0, "R2 random");
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule